// File: doc/BRIEF.md
# Byte-Wide Serializer/Deserializer with Facility and Equipment Loopback

This block is the digital core of a byte-wide line transceiver. On the transmit side it takes an 8-bit parallel word once per frame of eight high-speed transmit clocks and sends it out one bit per clock, most significant bit first. It also produces a transmit low-speed clock at one eighth of the high-speed rate, and a new word is captured on the edge where that clock rises. On the receive side it shifts in one serial bit per high-speed clock. On every eighth edge it registers a complete 8-bit word, together with a receive low-speed clock at one eighth of the rate. The word boundary is fixed from reset; there is no alignment search.

Two loopback controls reroute the serial paths for diagnostics. Facility loopback sends the incoming serial stream straight back out of the transmit serial pin, and the receiver keeps decoding that stream. Equipment loopback feeds the block's own serialized transmit stream into the deserializer instead of the receive pin. It also clocks the deserializer, and so the receive low-speed clock, from the transmit high-speed clock. When both controls are set, the deserializer takes the internal stream and the transmit pin carries the receive input.

A loss-of-signal input from the optics is synchronized into the deserializer clock domain, and its active level is chosen by a strap input. In normal mode an asserted loss-of-signal forces the parallel receive output to zero.

Top module: `serdes_loop_core`

## Requirements
- R1: In normal mode, the tx_word value present at the high-speed edge where tx_lsclk rises is captured. On that edge and the next seven edges tx_serial shows its bits from bit 7 down to bit 0, one bit per edge.
- R2: tx_lsclk repeats every 8 edges of hs_tx_clk and is high for the 4 edges after a capture edge. rx_lsclk has the same shape on the deserializer clock, and both counters leave reset on the same phase.
- R3: rx_word changes only on the edge where rx_lsclk rises. It then holds the deserializer input bits sampled on that edge and the seven edges before it: the earliest bit in bit 7 and the bit from that edge in bit 0.
- R4: While fac_loop is 1, tx_serial follows rx_serial combinationally.
- R5: With fac_loop 1 and eq_loop 0, the receiver still deserializes rx_serial onto rx_word as in R3.
- R6: While eq_loop is 1, the deserializer samples the internal serialized transmit bit and ignores rx_serial. The deserializer and rx_lsclk are clocked by hs_tx_clk.
- R7: With eq_loop 1 and fac_loop 0, tx_serial still carries the serialized transmit words as in R1.
- R8: With both loopbacks set, the deserializer takes the internal transmit stream and tx_serial carries rx_serial.
- R9: Loss of signal is active when los_in equals los_act_high. los_flag shows the active state two deserializer clock edges after los_in is driven.
- R10: When los_flag is 1 and both loopbacks are 0, rx_word is all zeros. In any loopback mode rx_word is not forced.
- R11: While rst_n is low with fac_loop 0, tx_serial, tx_lsclk, rx_lsclk, rx_word and los_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hs_tx_clk | input | 1 | High-speed transmit bit clock |
| hs_rx_clk | input | 1 | High-speed receive bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| tx_word | input | 8 | Parallel transmit word |
| tx_lsclk | output | 1 | Transmit low-speed clock, high-speed rate divided by 8 |
| tx_serial | output | 1 | High-speed transmit serial output |
| rx_serial | input | 1 | High-speed receive serial input |
| rx_word | output | 8 | Parallel receive word |
| rx_lsclk | output | 1 | Receive low-speed clock, deserializer clock divided by 8 |
| fac_loop | input | 1 | Facility loopback select |
| eq_loop | input | 1 | Equipment loopback select |
| los_in | input | 1 | Loss-of-signal indication from the optics |
| los_act_high | input | 1 | Level of los_in that means signal lost |
| los_flag | output | 1 | Synchronized loss-of-signal status |

## Verification
A wrong bit counter in either direction shows up as an early or late edge on tx_lsclk or rx_lsclk, which a phase check catches within the next frame of eight edges. It also shows up as a rotated or stale byte on rx_word at the next rising edge of rx_lsclk. A wrong loopback path selection gives a tx_serial that no longer matches the serialized word or the receive pin in the same cycle. In equipment mode it gives an rx_word that contains receive-pin bits instead of the transmitted byte one frame later. A broken polarity or synchronizer stage moves los_flag off its two-edge delay, and a missing blanking term lets a nonzero byte through in normal mode while the flag is set.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

  // Path selection, encoded as {equipment, facility}.
  typedef enum logic [1:0] {
    PATH_NORMAL    = 2'b00,
    PATH_FACILITY  = 2'b01,
    PATH_EQUIPMENT = 2'b10,
    PATH_BOTH      = 2'b11
  } path_e;

  function automatic path_e path_decode(input logic fac, input logic eqp);
    return path_e'({eqp, fac});
  endfunction

endpackage

// File: rtl/sdx_sync_chain.sv
// Multi-flop synchronizer. Reset value is 0; with d_i tied high it acts as
// a reset release synchronizer.
module sdx_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  always_comb begin
    st_d = {st_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/sdx_serializer.sv
// Parallel-to-serial converter, MSB first, new word every WORD_W clocks.
module sdx_serializer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o,
  output logic              lsclk_o
);

  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] HALF = CW'(WORD_W / 2);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              ls_q, ls_d;
  logic              load_en;

  always_comb begin
    load_en = (cnt_q == LAST);
    cnt_d   = load_en ? '0 : cnt_q + 1'b1;
    sh_d    = load_en ? word_i : {sh_q[WORD_W-2:0], 1'b0};
    ls_d    = (cnt_d < HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LAST;
      sh_q  <= '0;
      ls_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      ls_q  <= ls_d;
    end
  end

  assign bit_o   = sh_q[WORD_W-1];
  assign lsclk_o = ls_q;

endmodule

// File: rtl/sdx_deserializer.sv
// Serial-to-parallel converter with a fixed word boundary from reset.
module sdx_deserializer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              lsclk_o
);

  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] HALF = CW'(WORD_W / 2);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-2:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              ls_q, ls_d;
  logic              word_en;

  always_comb begin
    word_en = (cnt_q == LAST);
    cnt_d   = word_en ? '0 : cnt_q + 1'b1;
    sh_d    = {sh_q[WORD_W-3:0], bit_i};
    word_d  = word_en ? {sh_q, bit_i} : word_q;
    ls_d    = (cnt_d < HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LAST;
      sh_q   <= '0;
      word_q <= '0;
      ls_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      word_q <= word_d;
      ls_q   <= ls_d;
    end
  end

  assign word_o  = word_q;
  assign lsclk_o = ls_q;

endmodule

// File: rtl/serdes_loop_core.sv
module serdes_loop_core #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              hs_tx_clk,
  input  logic              hs_rx_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_lsclk,
  output logic              tx_serial,
  input  logic              rx_serial,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_lsclk,
  input  logic              fac_loop,
  input  logic              eq_loop,
  input  logic              los_in,
  input  logic              los_act_high,
  output logic              los_flag
);

  import sdx_pkg::*;

  path_e             path;
  logic              des_clk;
  logic              tx_srst_n;
  logic              des_srst_n;
  logic              ser_bit;
  logic              des_din;
  logic              los_raw;
  logic              los_q;
  logic [WORD_W-1:0] word_q;

  assign path = path_decode(fac_loop, eq_loop);

  // Deserializer clock source: transmit clock in equipment loopback.
  assign des_clk = eq_loop ? hs_tx_clk : hs_rx_clk;

  sdx_sync_chain #(.STAGES(SYNC_STAGES)) u_tx_rst (
    .clk    (hs_tx_clk),
    .arst_n (rst_n),
    .d_i    (1'b1),
    .q_o    (tx_srst_n)
  );

  sdx_sync_chain #(.STAGES(SYNC_STAGES)) u_des_rst (
    .clk    (des_clk),
    .arst_n (rst_n),
    .d_i    (1'b1),
    .q_o    (des_srst_n)
  );

  sdx_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk     (hs_tx_clk),
    .rst_n   (tx_srst_n),
    .word_i  (tx_word),
    .bit_o   (ser_bit),
    .lsclk_o (tx_lsclk)
  );

  // Equipment loopback wins for the deserializer input.
  assign des_din = eq_loop ? ser_bit : rx_serial;

  // Facility loopback wins for the transmit pin.
  assign tx_serial = fac_loop ? rx_serial : ser_bit;

  sdx_deserializer #(.WORD_W(WORD_W)) u_des (
    .clk     (des_clk),
    .rst_n   (des_srst_n),
    .bit_i   (des_din),
    .word_o  (word_q),
    .lsclk_o (rx_lsclk)
  );

  assign los_raw = ~(los_in ^ los_act_high);

  sdx_sync_chain #(.STAGES(SYNC_STAGES)) u_los_sync (
    .clk    (des_clk),
    .arst_n (des_srst_n),
    .d_i    (los_raw),
    .q_o    (los_q)
  );

  assign los_flag = los_q;
  assign rx_word  = (los_q && (path == PATH_NORMAL)) ? '0 : word_q;

endmodule

// File: rtl/sdx_checker.sv
module sdx_checker #(
  parameter int WORD_W = 8
) (
  input logic              hs_tx_clk,
  input logic              des_clk,
  input logic              tx_srst_n,
  input logic              des_srst_n,
  input logic              fac_loop,
  input logic              eq_loop,
  input logic              tx_lsclk,
  input logic              tx_serial,
  input logic [WORD_W-1:0] tx_word,
  input logic              rx_lsclk,
  input logic [WORD_W-1:0] rx_word,
  input logic              des_din,
  input logic              los_flag
);

  logic       prev_q;
  logic       seen_q;
  logic [7:0] gap_q;
  logic       rise;

  assign rise = tx_lsclk && !prev_q;

  always_ff @(posedge hs_tx_clk or negedge tx_srst_n) begin
    if (!tx_srst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      prev_q <= tx_lsclk;
      seen_q <= seen_q | rise;
      gap_q  <= rise ? 8'd0 : gap_q + 8'd1;
    end
  end

  AST_TX_FRAME_PERIOD: assert property (@(posedge hs_tx_clk) disable iff (!tx_srst_n)
    (rise && seen_q) |-> (gap_q == 8'(WORD_W - 1))); // R2

  AST_TX_MSB_FIRST: assert property (@(posedge hs_tx_clk) disable iff (!tx_srst_n)
    ($rose(tx_lsclk) && !fac_loop) |-> (tx_serial == $past(tx_word[WORD_W-1]))); // R1

  AST_RX_HOLD: assert property (@(posedge des_clk) disable iff (!des_srst_n)
    (!$rose(rx_lsclk) && $stable(los_flag) && $stable(fac_loop) && $stable(eq_loop))
      |-> $stable(rx_word)); // R3

  AST_RX_LAST_BIT: assert property (@(posedge des_clk) disable iff (!des_srst_n)
    ($rose(rx_lsclk) && !(los_flag && !fac_loop && !eq_loop))
      |-> (rx_word[0] == $past(des_din))); // R3

  AST_LOS_BLANK: assert property (@(posedge des_clk) disable iff (!des_srst_n)
    (los_flag && !fac_loop && !eq_loop) |-> (rx_word == '0)); // R10

endmodule

bind serdes_loop_core sdx_checker #(.WORD_W(WORD_W)) u_chk (
  .hs_tx_clk  (hs_tx_clk),
  .des_clk    (des_clk),
  .tx_srst_n  (tx_srst_n),
  .des_srst_n (des_srst_n),
  .fac_loop   (fac_loop),
  .eq_loop    (eq_loop),
  .tx_lsclk   (tx_lsclk),
  .tx_serial  (tx_serial),
  .tx_word    (tx_word),
  .rx_lsclk   (rx_lsclk),
  .rx_word    (rx_word),
  .des_din    (des_din),
  .los_flag   (los_flag)
);

// File: tb/sim_serdes_loop_core.sv
`timescale 1ns/1ps
module sim_serdes_loop_core;

  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n;
  logic         fac, eqp, rx_ser, los_in, los_pol;
  logic [W-1:0] txw;
  logic         tx_ls, tx_ser, rx_ls, los_flag;
  logic [W-1:0] rxw;

  serdes_loop_core #(.WORD_W(W)) u0 (
    .hs_tx_clk    (clk),
    .hs_rx_clk    (clk),
    .rst_n        (rst_n),
    .tx_word      (txw),
    .tx_lsclk     (tx_ls),
    .tx_serial    (tx_ser),
    .rx_serial    (rx_ser),
    .rx_word      (rxw),
    .rx_lsclk     (rx_ls),
    .fac_loop     (fac),
    .eq_loop      (eqp),
    .los_in       (los_in),
    .los_act_high (los_pol),
    .los_flag     (los_flag)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench reference state
  bit           locked = 0;
  int           phase  = 0;
  int           rises  = 0;
  logic [W-1:0] cap    = '0;
  logic [W-1:0] hist   = '0;
  logic         q1     = 1'b0;
  logic         q2     = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string rx_tag(input logic f, input logic e, input logic blank);
    if (blank)   return "R10 rx_word blanked";
    if (e && f)  return "R8 rx_word both loops";
    if (e)       return "R6 rx_word equipment";
    if (f)       return "R5 rx_word facility";
    return "R3 rx_word normal";
  endfunction

  task automatic cyc(input logic f, input logic e, input logic [W-1:0] w,
                     input logic r, input logic l, input logic p);
    logic [W-1:0] exp_w;
    logic         blank;
    logic         ser_exp;
    @(negedge clk);
    if (!locked) begin
      if (tx_ls) begin locked = 1; phase = 0; end
    end else begin
      phase = (phase + 1) % W;
    end
    if (locked) begin
      chk(tx_ls == (phase < W/2), "R2 tx_lsclk phase", tx_ls, (phase < W/2));
      chk(rx_ls == (phase < W/2), "R2 rx_lsclk phase", rx_ls, (phase < W/2));
      chk(los_flag == q2, "R9 los_flag delay/polarity", los_flag, q2);
      if (los_flag && !fac && !eqp) chk(rxw == '0, "R10 blank while lost", rxw, '0);
      if (phase == 0) begin
        cap = txw;
        rises++;
        if (rises >= 2) begin
          blank = q2 && !fac && !eqp;
          exp_w = blank ? '0 : hist;
          chk(rxw == exp_w, rx_tag(fac, eqp, blank), rxw, exp_w);
        end
      end
    end
    fac = f; eqp = e; txw = w; rx_ser = r; los_in = l; los_pol = p;
    #1;
    if (locked) begin
      ser_exp = cap[W-1-phase];
      if (f) chk(tx_ser == r, e ? "R8 tx_serial both loops" : "R4 tx_serial facility", tx_ser, r);
      else   chk(tx_ser == ser_exp, e ? "R7 tx_serial equipment" : "R1 tx_serial MSB first", tx_ser, ser_exp);
      hist = {hist[W-2:0], (e ? ser_exp : r)};
    end
    q2 = q1;
    q1 = (l == p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic r, l;
    void'($urandom(32'h5EED_0C7A));
    rst_n = 1'b0; fac = 1'b0; eqp = 1'b0; txw = '0; rx_ser = 1'b0;
    los_in = 1'b0; los_pol = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_ser == 1'b0,   "R11 reset tx_serial", tx_ser, 0);
    chk(tx_ls == 1'b0,    "R11 reset tx_lsclk", tx_ls, 0);
    chk(rx_ls == 1'b0,    "R11 reset rx_lsclk", rx_ls, 0);
    chk(rxw == '0,        "R11 reset rx_word", rxw, 0);
    chk(los_flag == 1'b0, "R11 reset los_flag", los_flag, 0);
    rst_n = 1'b1;

    // Directed words in normal mode and in equipment loopback
    for (int k = 0; k < 2; k++) begin
      for (int j = 0; j < 24; j++) cyc(1'b0, k[0], 8'hFF, 1'b1, 1'b0, 1'b1);
      for (int j = 0; j < 24; j++) cyc(1'b0, k[0], 8'h00, 1'b0, 1'b0, 1'b1);
      for (int j = 0; j < 24; j++) cyc(1'b0, k[0], 8'h80, 1'b1, 1'b0, 1'b1);
      for (int j = 0; j < 24; j++) cyc(1'b0, k[0], 8'h01, 1'b0, 1'b0, 1'b1);
    end

    // Random traffic across all paths and both loss polarities
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < 320; i++) begin
          r = 1'($urandom);
          l = (((i / 40) % 3) == 1) ? p[0] : ~p[0];
          if (($urandom % 16) == 0) l = ~l;
          cyc(m[0], m[1], W'($urandom), r, l, p[0]);
        end
      end
    end

    // Loss asserted, then switch into and out of loopback
    for (int j = 0; j < 32; j++) cyc(1'b0, 1'b0, W'($urandom), 1'($urandom), 1'b1, 1'b1);
    for (int j = 0; j < 32; j++) cyc(1'b1, 1'b0, W'($urandom), 1'($urandom), 1'b1, 1'b1);
    for (int j = 0; j < 32; j++) cyc(1'b0, 1'b1, W'($urandom), 1'($urandom), 1'b1, 1'b1);
    for (int j = 0; j < 32; j++) cyc(1'b0, 1'b0, W'($urandom), 1'($urandom), 1'b0, 1'b0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule